// File: doc/BRIEF.md
# Delayed Read Retry Controller

This block runs the target-side attempts of one queued delayed read inside a bus bridge. When a new delayed read is accepted, it asks the target-side master to issue the read. It then waits for the termination that ends that attempt. If the target answers with retry, the read is issued again. The attempts end when data moves (a normal completion or a disconnect), when a master abort or a target abort arrives, or when a retry counter reaches its limit.

Each ending is turned into a single response code for the original initiator. A target abort also pulses two status flags, one for each side of the bridge. When the retries run out, the block gives a system-error request, but only if that report is enabled and not disabled. The parameter `RETRY_LIMIT` sets the limit. Its default is 2^24 retries, held in a 24-bit counter that is cleared each time a new read is accepted.

The state machine has three states. `ST_IDLE` waits for a request. `ST_ISSUE` drives the issue strobe for one cycle. `ST_WAIT` waits for the termination. The transitions are:
- `ST_IDLE`→`ST_ISSUE` when a request is accepted.
- `ST_ISSUE`→`ST_WAIT` always.
- `ST_WAIT`→`ST_ISSUE` on a retry below the limit.
- `ST_WAIT`→`ST_IDLE` on any other termination, or on the retry that reaches the limit.

Top module: `dr_retry_ctrl`

## Requirements
- R1: While reset is held and after it is released, `issue_rd`, `rsp_valid`, `rcvd_tabort`, `sig_tabort` and `serr_req` are low and `rsp_code` is 0.
- R2: A `req_start` sampled in the idle state raises `issue_rd` for exactly one cycle, starting the next cycle, and clears the retry counter.
- R3: A termination code 1 (retry) that is below the limit raises `issue_rd` again in the cycle after it is sampled, and produces no response.
- R4: Termination code 0 (normal) on a prefetchable read gives response 2 (disconnect) if `init_cnt` > `tgt_cnt`, and response 1 (complete) otherwise.
- R5: Termination code 0 on a non-prefetchable read always gives response 2 (disconnect).
- R6: Termination code 2 (disconnect) gives response 2 if `init_cnt` > `tgt_cnt`, and response 1 otherwise.
- R7: Termination code 3 with `term_mabort` low gives response 3 (target abort) and pulses both `rcvd_tabort` and `sig_tabort` together with the response.
- R8: Termination code 3 with `term_mabort` high gives response 4 (master abort). It does not raise `serr_req` and does not raise either target-abort flag.
- R9: The `RETRY_LIMIT`-th consecutive retry gives response 5 (expired) and does not issue the read again.
- R10: `serr_req` pulses together with response 5 exactly when `serr_en` is 1 and `nodeliv_dis` is 0.
- R11: `req_start` has no effect while a read is in progress, and `term_valid` has no effect while idle.
- R12: A response appears in the cycle after its termination is sampled and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | New delayed read accepted |
| term_valid | input | 1 | One-cycle strobe marking that `term_code` is valid |
| term_code | input | 2 | Termination: 0 normal, 1 retry, 2 disconnect, 3 abort |
| term_mabort | input | 1 | With code 3: 1 means master abort, 0 means target abort |
| prefetch | input | 1 | The read is prefetchable |
| init_cnt | input | DCNT_W | Data count requested by the initiator |
| tgt_cnt | input | DCNT_W | Data count read from the target |
| serr_en | input | 1 | System-error report enable |
| nodeliv_dis | input | 1 | Disables the non-delivery error report |
| issue_rd | output | 1 | Issue the read on the target bus |
| rsp_valid | output | 1 | Response to the initiator is valid |
| rsp_code | output | 3 | 1 complete, 2 disconnect, 3 target abort, 4 master abort, 5 expired |
| rcvd_tabort | output | 1 | Received-target-abort status pulse (target side) |
| sig_tabort | output | 1 | Signaled-target-abort status pulse (initiator side) |
| serr_req | output | 1 | System-error request pulse |

## Verification
`issue_rd` is due one cycle after the `req_start` or retry that causes it. The response, the status pulses and `serr_req` are all due one cycle after the terminating `term_valid`. The bench drives every input on a falling edge and samples on the next falling edge. This places each observation exactly one rising edge after its cause. One further falling edge later, the bench confirms that each pulse has dropped. A small `RETRY_LIMIT` lets the bench reach the expiry path, and then check that a following read starts its count from zero.

// File: rtl/dr_retry_pkg.sv
package dr_retry_pkg;
    typedef enum logic [1:0] {
        TERM_NORMAL = 2'd0,
        TERM_RETRY  = 2'd1,
        TERM_DISC   = 2'd2,
        TERM_ABORT  = 2'd3
    } term_e;

    typedef enum logic [2:0] {
        RSP_NONE     = 3'd0,
        RSP_COMPLETE = 3'd1,
        RSP_DISC     = 3'd2,
        RSP_TABORT   = 3'd3,
        RSP_MABORT   = 3'd4,
        RSP_EXPIRED  = 3'd5
    } rsp_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } state_e;
endpackage

// File: rtl/dr_attempt_ctr.sv
module dr_attempt_ctr #(
    parameter int CNT_W       = 24,
    parameter int RETRY_LIMIT = 1 << 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic at_last
);
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(RETRY_LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear)
            cnt_q <= '0;
        else if (bump)
            cnt_q <= cnt_q + 1'b1;
    end

    generate
        if (RETRY_LIMIT <= 1) begin : g_single
            assign at_last = 1'b1;
        end else begin : g_count
            assign at_last = (cnt_q == LAST_VAL);
        end
    endgenerate
endmodule

// File: rtl/dr_resp_map.sv
module dr_resp_map
    import dr_retry_pkg::*;
#(
    parameter int DCNT_W = 8
) (
    input  term_e             code,
    input  logic              mabort,
    input  logic              prefetch,
    input  logic [DCNT_W-1:0] init_cnt,
    input  logic [DCNT_W-1:0] tgt_cnt,
    output rsp_e              rsp,
    output logic              tabort
);
    logic wants_more;
    assign wants_more = (init_cnt > tgt_cnt);

    always_comb begin
        rsp    = RSP_NONE;
        tabort = 1'b0;
        unique case (code)
            TERM_NORMAL: rsp = (!prefetch || wants_more) ? RSP_DISC : RSP_COMPLETE;
            TERM_DISC:   rsp = wants_more ? RSP_DISC : RSP_COMPLETE;
            TERM_ABORT: begin
                rsp    = mabort ? RSP_MABORT : RSP_TABORT;
                tabort = !mabort;
            end
            TERM_RETRY:  rsp = RSP_NONE;
            default:     rsp = RSP_NONE;
        endcase
    end
endmodule

// File: rtl/dr_retry_ctrl.sv
module dr_retry_ctrl
    import dr_retry_pkg::*;
#(
    parameter int DCNT_W      = 8,
    parameter int CNT_W       = 24,
    parameter int RETRY_LIMIT = 1 << 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic              term_valid,
    input  logic [1:0]        term_code,
    input  logic              term_mabort,
    input  logic              prefetch,
    input  logic [DCNT_W-1:0] init_cnt,
    input  logic [DCNT_W-1:0] tgt_cnt,
    input  logic              serr_en,
    input  logic              nodeliv_dis,
    output logic              issue_rd,
    output logic              rsp_valid,
    output logic [2:0]        rsp_code,
    output logic              rcvd_tabort,
    output logic              sig_tabort,
    output logic              serr_req
);
    state_e state_q, state_d;
    term_e  code;
    rsp_e   map_rsp;
    logic   map_tabort;
    logic   at_last;
    logic   sampled;
    logic   is_retry;

    assign code     = term_e'(term_code);
    assign sampled  = (state_q == ST_WAIT) && term_valid;
    assign is_retry = (code == TERM_RETRY);

    dr_attempt_ctr #(.CNT_W(CNT_W), .RETRY_LIMIT(RETRY_LIMIT)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   ((state_q == ST_IDLE) && req_start),
        .bump    (sampled && is_retry),
        .at_last (at_last)
    );

    dr_resp_map #(.DCNT_W(DCNT_W)) u_map (
        .code     (code),
        .mabort   (term_mabort),
        .prefetch (prefetch),
        .init_cnt (init_cnt),
        .tgt_cnt  (tgt_cnt),
        .rsp      (map_rsp),
        .tabort   (map_tabort)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_start) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT: begin
                if (term_valid)
                    state_d = (is_retry && !at_last) ? ST_ISSUE : ST_IDLE;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign issue_rd = (state_q == ST_ISSUE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_code    <= RSP_NONE;
            rcvd_tabort <= 1'b0;
            sig_tabort  <= 1'b0;
            serr_req    <= 1'b0;
        end else begin
            rsp_valid   <= 1'b0;
            rsp_code    <= RSP_NONE;
            rcvd_tabort <= 1'b0;
            sig_tabort  <= 1'b0;
            serr_req    <= 1'b0;
            if (sampled) begin
                if (is_retry) begin
                    if (at_last) begin
                        rsp_valid <= 1'b1;
                        rsp_code  <= RSP_EXPIRED;
                        serr_req  <= serr_en && !nodeliv_dis;
                    end
                end else begin
                    rsp_valid   <= 1'b1;
                    rsp_code    <= map_rsp;
                    rcvd_tabort <= map_tabort;
                    sig_tabort  <= map_tabort;
                end
            end
        end
    end
endmodule

// File: rtl/dr_retry_chk.sv
module dr_retry_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_start,
    input logic       term_valid,
    input logic       issue_rd,
    input logic       rsp_valid,
    input logic [2:0] rsp_code,
    input logic       rcvd_tabort,
    input logic       sig_tabort,
    input logic       serr_req
);
    // R12
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R2
    issue_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_rd |=> !issue_rd);

    // R7
    tabort_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rcvd_tabort |-> (sig_tabort && rsp_valid && rsp_code == 3'd3));

    // R7
    tabort_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sig_tabort |-> rcvd_tabort);

    // R10
    serr_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serr_req |-> (rsp_valid && rsp_code == 3'd5));

    // R8
    mabort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 3'd4) |-> (!serr_req && !rcvd_tabort));

    // R12
    no_issue_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !issue_rd);
endmodule

bind dr_retry_ctrl dr_retry_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_start   (req_start),
    .term_valid  (term_valid),
    .issue_rd    (issue_rd),
    .rsp_valid   (rsp_valid),
    .rsp_code    (rsp_code),
    .rcvd_tabort (rcvd_tabort),
    .sig_tabort  (sig_tabort),
    .serr_req    (serr_req)
);

// File: tb/dr_retry_ctrl_test.sv
module dr_retry_ctrl_test;
    localparam int LIMIT = 4;
    localparam int NV    = 13;

    typedef struct packed {
        logic       pf;
        logic [7:0] ic;
        logic [7:0] tc;
        logic [1:0] code;
        logic       mab;
        logic [3:0] nret;
        logic       en;
        logic       dis;
        logic [2:0] rsp;
        logic       tab;
        logic       serr;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'd4, 8'd4, 2'd0, 1'b0, 4'd0, 1'b1, 1'b0, 3'd1, 1'b0, 1'b0},
        '{1'b1, 8'd8, 8'd4, 2'd0, 1'b0, 4'd0, 1'b1, 1'b0, 3'd2, 1'b0, 1'b0},
        '{1'b0, 8'd1, 8'd1, 2'd0, 1'b0, 4'd0, 1'b1, 1'b0, 3'd2, 1'b0, 1'b0},
        '{1'b1, 8'd8, 8'd4, 2'd2, 1'b0, 4'd0, 1'b1, 1'b0, 3'd2, 1'b0, 1'b0},
        '{1'b1, 8'd4, 8'd4, 2'd2, 1'b0, 4'd0, 1'b1, 1'b0, 3'd1, 1'b0, 1'b0},
        '{1'b1, 8'd4, 8'd4, 2'd3, 1'b0, 4'd0, 1'b1, 1'b0, 3'd3, 1'b1, 1'b0},
        '{1'b1, 8'd4, 8'd4, 2'd3, 1'b1, 4'd0, 1'b1, 1'b0, 3'd4, 1'b0, 1'b0},
        '{1'b1, 8'd4, 8'd4, 2'd0, 1'b0, 4'd2, 1'b1, 1'b0, 3'd1, 1'b0, 1'b0},
        '{1'b1, 8'd4, 8'd4, 2'd0, 1'b0, 4'd4, 1'b1, 1'b0, 3'd5, 1'b0, 1'b1},
        '{1'b1, 8'd4, 8'd4, 2'd0, 1'b0, 4'd4, 1'b0, 1'b0, 3'd5, 1'b0, 1'b0},
        '{1'b1, 8'd4, 8'd4, 2'd0, 1'b0, 4'd4, 1'b1, 1'b1, 3'd5, 1'b0, 1'b0},
        '{1'b1, 8'd4, 8'd4, 2'd3, 1'b1, 4'd3, 1'b1, 1'b0, 3'd4, 1'b0, 1'b0},
        '{1'b0, 8'd2, 8'd2, 2'd2, 1'b0, 4'd3, 1'b1, 1'b0, 3'd1, 1'b0, 1'b0}
    };

    function automatic string vec_tag(int idx);
        case (idx)
            0, 1:   return "R4";
            2:      return "R5";
            3, 4:   return "R6";
            5:      return "R7";
            6, 11:  return "R8";
            7, 12:  return "R3";
            8:      return "R9";
            default: return "R10";
        endcase
    endfunction

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_start = 1'b0;
    logic       term_valid = 1'b0;
    logic [1:0] term_code = 2'd0;
    logic       term_mabort = 1'b0;
    logic       prefetch = 1'b0;
    logic [7:0] init_cnt = 8'd0;
    logic [7:0] tgt_cnt = 8'd0;
    logic       serr_en = 1'b0;
    logic       nodeliv_dis = 1'b0;
    logic       issue_rd, rsp_valid, rcvd_tabort, sig_tabort, serr_req;
    logic [2:0] rsp_code;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    dr_retry_ctrl #(.DCNT_W(8), .CNT_W(24), .RETRY_LIMIT(LIMIT)) uut (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .term_valid(term_valid),
        .term_code(term_code), .term_mabort(term_mabort), .prefetch(prefetch),
        .init_cnt(init_cnt), .tgt_cnt(tgt_cnt), .serr_en(serr_en),
        .nodeliv_dis(nodeliv_dis), .issue_rd(issue_rd), .rsp_valid(rsp_valid),
        .rsp_code(rsp_code), .rcvd_tabort(rcvd_tabort), .sig_tabort(sig_tabort),
        .serr_req(serr_req)
    );

    task automatic chk(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic give_term(logic [1:0] c, logic m);
        term_valid  = 1'b1;
        term_code   = c;
        term_mabort = m;
        @(negedge clk);
        term_valid  = 1'b0;
    endtask

    task automatic check_rsp(string tag, int rsp, int tab, int serr);
        chk(tag, "rsp_valid", int'(rsp_valid), 1);
        chk(tag, "rsp_code", int'(rsp_code), rsp);
        chk(tag, "rcvd_tabort", int'(rcvd_tabort), tab);
        chk(tag, "sig_tabort", int'(sig_tabort), tab);
        chk(tag, "serr_req", int'(serr_req), serr);
        chk(tag, "issue_rd after end", int'(issue_rd), 0);
        @(negedge clk);
        chk("R12", "rsp_valid drops", int'(rsp_valid), 0);
    endtask

    task automatic run_vec(int idx);
        vec_t v = VECS[idx];
        string tag = vec_tag(idx);
        prefetch = v.pf; init_cnt = v.ic; tgt_cnt = v.tc;
        serr_en = v.en; nodeliv_dis = v.dis;
        req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        chk("R2", "issue_rd", int'(issue_rd), 1);
        @(negedge clk);
        for (int i = 0; i < int'(v.nret); i++) begin
            give_term(2'd1, 1'b0);
            if (i == LIMIT - 1) begin
                check_rsp(tag, int'(v.rsp), int'(v.tab), int'(v.serr));
                return;
            end
            chk("R3", "reissue", int'(issue_rd), 1);
            chk("R3", "no rsp on retry", int'(rsp_valid), 0);
            @(negedge clk);
        end
        give_term(v.code, v.mab);
        check_rsp(tag, int'(v.rsp), int'(v.tab), int'(v.serr));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "issue_rd in reset", int'(issue_rd), 0);
        chk("R1", "rsp_valid in reset", int'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "rsp_code", int'(rsp_code), 0);
        chk("R1", "serr_req", int'(serr_req), 0);
        chk("R1", "tabort flags", int'(rcvd_tabort | sig_tabort), 0);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R11: termination strobe while idle is ignored
        give_term(2'd3, 1'b0);
        chk("R11", "rsp_valid idle term", int'(rsp_valid), 0);
        chk("R11", "rcvd_tabort idle term", int'(rcvd_tabort), 0);
        chk("R11", "issue_rd idle term", int'(issue_rd), 0);

        // R11: new request while waiting is ignored
        prefetch = 1'b1; init_cnt = 8'd3; tgt_cnt = 8'd3;
        req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        chk("R2", "issue_rd", int'(issue_rd), 1);
        @(negedge clk);
        req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        chk("R11", "issue_rd busy req", int'(issue_rd), 0);
        give_term(2'd0, 1'b0);
        check_rsp("R11", 1, 0, 0);
        chk("R11", "no late issue", int'(issue_rd), 0);

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule